// File: doc/BRIEF.md
# Skip Condition Test Unit

This unit decides whether a 4-bit controller skips the next instruction after one of its conditional test opcodes. It watches the instruction byte stream, qualified by a valid strobe, and compares the current carry flag, accumulator, addressed RAM nibble and 4-bit G port against the condition the opcode names. One registered skip request comes out for each test.

Tests on the G port use a two-byte form whose first byte is 0x33. A small state machine remembers that this prefix has been seen. The sticky timer-event flag is set by a pulse from an external time-base counter, and the timer test reads it and clears it.

The state machine has two states. `ST_IDLE` means a first byte is expected. `ST_EXT` means a prefix has been accepted and a second byte is expected. There are three transitions:
- `PREFIX_SEEN` goes from `ST_IDLE` to `ST_EXT` when a valid 0x33 arrives.
- `SECOND_TAKEN` goes from `ST_EXT` to `ST_IDLE` when any valid byte arrives.
- `WAIT_SECOND` stays in `ST_EXT` while the valid strobe is low.

Every other case stays in `ST_IDLE`.

Top module: `skip_test_unit`

## Requirements
- R1: After reset, `skip` is 0, the machine is in `ST_IDLE`, and the timer-event flag is clear, so a timer test made before any carry pulse gives no skip.
- R2: In `ST_IDLE`, opcode 0x20 requests a skip exactly when `carry_in` is 1.
- R3: In `ST_IDLE`, opcode 0x21 requests a skip exactly when `acc` equals `ram_nib`.
- R4: In `ST_IDLE`, opcodes 0x01, 0x11, 0x03 and 0x13 test `ram_nib` bits 0, 1, 2 and 3 respectively. The bit index is {opcode bit 1, opcode bit 4}. Each opcode requests a skip when the selected bit is 0.
- R5: Prefix 0x33 followed by 0x21 requests a skip exactly when all four `gport` bits are 0.
- R6: Prefix 0x33 followed by 0x01, 0x11, 0x03 or 0x13 tests `gport` bit 0, 1, 2 or 3 respectively, and requests a skip when that bit is 0.
- R7: In `ST_IDLE`, opcode 0x41 requests a skip exactly when the timer-event flag is set, and the flag is cleared by that test.
- R8: A `tb_carry` pulse sets the timer-event flag. If the pulse arrives in the same cycle as a 0x41 test, the flag stays set afterwards.
- R9: After a prefix, the machine stays in `ST_EXT` through cycles with `instr_valid` low. Any second byte outside the table of R5 and R6 (including 0x41 and 0x33) gives no skip and returns to `ST_IDLE`.
- R10: `skip` is high only in the cycle following the deciding valid byte, and only for one cycle. Opcodes that are not tests give no skip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | `instr_byte` holds a byte this cycle |
| instr_byte | input | 8 | Instruction byte |
| carry_in | input | 1 | Carry flag C |
| acc | input | 4 | Accumulator A |
| ram_nib | input | 4 | RAM nibble at the current address |
| gport | input | 4 | G port value |
| tb_carry | input | 1 | One-cycle pulse on time-base counter carry |
| skip | output | 1 | Skip request for the next instruction slot |

## Verification
Each test opcode is driven with operand values that make its condition true and values that make it false. The RAM and G bit tests are also driven with walking-zero and walking-one nibbles, which exposes any bit index swapped by the irregular opcode code. The same second bytes are sent with and without the prefix, which separates the RAM tests from the G tests and the A-equals-RAM test from the G-zero test. Timer tests are run with no pulse, with a pulse beforehand and with a pulse in the same cycle, which tells a sticky flag that is cleared correctly from one that is level-sensitive or never cleared.

// File: rtl/skip_test_pkg.sv
package skip_test_pkg;

    localparam int NIB_W   = 4;
    localparam int OP_W    = 8;
    localparam int BSEL_W  = $clog2(NIB_W);

    localparam logic [OP_W-1:0] OP_PREFIX = 8'h33;
    localparam logic [OP_W-1:0] OP_CARRY  = 8'h20;
    localparam logic [OP_W-1:0] OP_EQUAL  = 8'h21;
    localparam logic [OP_W-1:0] OP_TIMER  = 8'h41;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXT
    } seq_state_e;

    typedef enum logic [2:0] {
        TK_NONE,
        TK_CARRY,
        TK_AEQM,
        TK_MBIT,
        TK_GZERO,
        TK_GBIT,
        TK_TIMER,
        TK_PREFIX
    } test_kind_e;

    // Bit-test codes: low nibble 1 or 3, high nibble 0 or 1.
    function automatic logic is_bit_code(input logic [OP_W-1:0] op);
        return (op[7:5] == 3'b000) && (op[3:2] == 2'b00) && (op[0] == 1'b1);
    endfunction

    // Irregular index: bit 1 of opcode is the high index bit, bit 4 the low.
    function automatic logic [BSEL_W-1:0] bit_code_index(input logic [OP_W-1:0] op);
        return {op[1], op[4]};
    endfunction

endpackage

// File: rtl/stu_decode.sv
module stu_decode
    import skip_test_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic              ext_mode,
    output test_kind_e        kind,
    output logic [BSEL_W-1:0] bsel
);

    always_comb begin
        kind = TK_NONE;
        bsel = bit_code_index(op);
        if (ext_mode) begin
            if (op == OP_EQUAL)
                kind = TK_GZERO;
            else if (is_bit_code(op))
                kind = TK_GBIT;
        end else begin
            if (op == OP_PREFIX)
                kind = TK_PREFIX;
            else if (op == OP_CARRY)
                kind = TK_CARRY;
            else if (op == OP_EQUAL)
                kind = TK_AEQM;
            else if (op == OP_TIMER)
                kind = TK_TIMER;
            else if (is_bit_code(op))
                kind = TK_MBIT;
        end
    end

endmodule

// File: rtl/stu_timer_flag.sv
module stu_timer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clear_req,
    output logic flag
);

    // A set in the same cycle as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_pulse)
            flag <= 1'b1;
        else if (clear_req)
            flag <= 1'b0;
    end

endmodule

// File: rtl/stu_eval.sv
module stu_eval
    import skip_test_pkg::*;
(
    input  test_kind_e        kind,
    input  logic [BSEL_W-1:0] bsel,
    input  logic              carry_in,
    input  logic [NIB_W-1:0]  acc,
    input  logic [NIB_W-1:0]  ram_nib,
    input  logic [NIB_W-1:0]  gport,
    input  logic              timer_flag,
    output logic              take
);

    logic [NIB_W-1:0] ram_zero;
    logic [NIB_W-1:0] g_zero;

    for (genvar i = 0; i < NIB_W; i++) begin : g_bitz
        assign ram_zero[i] = ~ram_nib[i];
        assign g_zero[i]   = ~gport[i];
    end

    always_comb begin
        unique case (kind)
            TK_CARRY:  take = carry_in;
            TK_AEQM:   take = (acc == ram_nib);
            TK_MBIT:   take = ram_zero[bsel];
            TK_GZERO:  take = &g_zero;
            TK_GBIT:   take = g_zero[bsel];
            TK_TIMER:  take = timer_flag;
            TK_PREFIX: take = 1'b0;
            TK_NONE:   take = 1'b0;
            default:   take = 1'b0;
        endcase
    end

endmodule

// File: rtl/skip_test_unit.sv
module skip_test_unit
    import skip_test_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [7:0]       instr_byte,
    input  logic             carry_in,
    input  logic [3:0]       acc,
    input  logic [3:0]       ram_nib,
    input  logic [3:0]       gport,
    input  logic             tb_carry,
    output logic             skip
);

    seq_state_e        state_q, state_d;
    test_kind_e        kind;
    logic [BSEL_W-1:0] bsel;
    logic              ext_mode;
    logic              cond_true;
    logic              timer_flag;
    logic              timer_clear;
    logic              skip_d;

    assign ext_mode = (state_q == ST_EXT);

    stu_decode u_decode (
        .op       (instr_byte),
        .ext_mode (ext_mode),
        .kind     (kind),
        .bsel     (bsel)
    );

    stu_eval u_eval (
        .kind       (kind),
        .bsel       (bsel),
        .carry_in   (carry_in),
        .acc        (acc),
        .ram_nib    (ram_nib),
        .gport      (gport),
        .timer_flag (timer_flag),
        .take       (cond_true)
    );

    assign timer_clear = instr_valid && (kind == TK_TIMER);

    stu_timer_flag u_tflag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (tb_carry),
        .clear_req (timer_clear),
        .flag      (timer_flag)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (instr_valid && kind == TK_PREFIX) state_d = ST_EXT;  // PREFIX_SEEN
            ST_EXT:  if (instr_valid) state_d = ST_IDLE;                      // SECOND_TAKEN / WAIT_SECOND
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output logic.
    assign skip_d = instr_valid && cond_true;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            skip <= 1'b0;
        else
            skip <= skip_d;
    end

endmodule

// File: rtl/skip_test_unit_chk.sv
module skip_test_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic [7:0] instr_byte,
    input logic       carry_in,
    input logic [3:0] acc,
    input logic [3:0] ram_nib,
    input logic [3:0] gport,
    input logic       tb_carry,
    input logic       skip,
    input logic       ext_mode,
    input logic       timer_flag
);

    // R10
    skip_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> $past(instr_valid));

    // R2
    carry_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && instr_valid && instr_byte == 8'h20) |=> (skip == $past(carry_in)));

    // R3
    aeqm_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && instr_valid && instr_byte == 8'h21) |=> (skip == ($past(acc) == $past(ram_nib))));

    // R5
    gzero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && instr_valid && instr_byte == 8'h21) |=> (skip == ($past(gport) == 4'h0)));

    // R7
    timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && instr_valid && instr_byte == 8'h41 && !tb_carry) |=> !timer_flag);

    // R8
    timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tb_carry |=> timer_flag);

    // R9
    hold_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && !instr_valid) |=> ext_mode);

endmodule

bind skip_test_unit skip_test_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_byte  (instr_byte),
    .carry_in    (carry_in),
    .acc         (acc),
    .ram_nib     (ram_nib),
    .gport       (gport),
    .tb_carry    (tb_carry),
    .skip        (skip),
    .ext_mode    (ext_mode),
    .timer_flag  (timer_flag)
);

// File: tb/skip_test_unit_tb.sv
`timescale 1ns/1ps
module skip_test_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [7:0] instr_byte = 8'h00;
    logic       carry_in = 1'b0;
    logic [3:0] acc = 4'h0;
    logic [3:0] ram_nib = 4'h0;
    logic [3:0] gport = 4'h0;
    logic       tb_carry = 1'b0;
    logic       skip;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    skip_test_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_byte  (instr_byte),
        .carry_in    (carry_in),
        .acc         (acc),
        .ram_nib     (ram_nib),
        .gport       (gport),
        .tb_carry    (tb_carry),
        .skip        (skip)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: skip=%0b expected %0b", req, act, exp);
        end
    endtask

    // Present one byte; return skip seen in the following cycle.
    task automatic send(input logic [7:0] b, output logic res);
        @(negedge clk);
        instr_byte  = b;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        res = skip;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic pulse_carry();
        @(negedge clk);
        tb_carry = 1'b1;
        @(negedge clk);
        tb_carry = 1'b0;
    endtask

    task automatic t_reset();
        logic r;
        check("R1 reset skip", skip, 1'b0);
        send(8'h41, r);
        check("R1 timer flag clear after reset", r, 1'b0);
    endtask

    task automatic t_carry();
        logic r;
        carry_in = 1'b1; send(8'h20, r); check("R2 C=1", r, 1'b1);
        idle_cycle();    check("R10 pulse ends", skip, 1'b0);
        carry_in = 1'b0; send(8'h20, r); check("R2 C=0", r, 1'b0);
    endtask

    task automatic t_aeqm();
        logic r;
        acc = 4'h9; ram_nib = 4'h9; send(8'h21, r); check("R3 equal", r, 1'b1);
        acc = 4'h9; ram_nib = 4'h8; send(8'h21, r); check("R3 differ", r, 1'b0);
        acc = 4'h0; ram_nib = 4'h0; gport = 4'hF; send(8'h21, r); check("R3 no prefix ignores G", r, 1'b1);
    endtask

    task automatic t_ram_bits();
        logic r;
        logic [7:0] codes [4] = '{8'h01, 8'h11, 8'h03, 8'h13};
        for (int i = 0; i < 4; i++) begin
            ram_nib = ~(4'b1 << i); gport = 4'hF;
            send(codes[i], r); check("R4 selected RAM bit zero", r, 1'b1);
            ram_nib = (4'b1 << i); gport = 4'h0;
            send(codes[i], r); check("R4 selected RAM bit one", r, 1'b0);
        end
    endtask

    task automatic t_gzero();
        logic r;
        acc = 4'h3; ram_nib = 4'h5;
        gport = 4'h0; send(8'h33, r); check("R10 prefix no skip", r, 1'b0);
        send(8'h21, r); check("R5 G zero", r, 1'b1);
        gport = 4'h4; send(8'h33, r); send(8'h21, r); check("R5 G nonzero", r, 1'b0);
    endtask

    task automatic t_g_bits();
        logic r;
        logic [7:0] codes [4] = '{8'h01, 8'h11, 8'h03, 8'h13};
        for (int i = 0; i < 4; i++) begin
            gport = ~(4'b1 << i); ram_nib = 4'hF;
            send(8'h33, r); send(codes[i], r); check("R6 selected G bit zero", r, 1'b1);
            gport = (4'b1 << i); ram_nib = 4'h0;
            send(8'h33, r); send(codes[i], r); check("R6 selected G bit one", r, 1'b0);
        end
    endtask

    task automatic t_timer();
        logic r;
        pulse_carry();
        send(8'h41, r); check("R7 event seen", r, 1'b1);
        send(8'h41, r); check("R7 cleared by test", r, 1'b0);
        pulse_carry();
        @(negedge clk);
        instr_byte = 8'h41; instr_valid = 1'b1; tb_carry = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0; tb_carry = 1'b0;
        check("R8 test with same-cycle pulse", skip, 1'b1);
        send(8'h41, r); check("R8 flag kept by same-cycle pulse", r, 1'b1);
        send(8'h41, r); check("R7 cleared afterwards", r, 1'b0);
    endtask

    task automatic t_prefix_wait();
        logic r;
        gport = 4'h0;
        send(8'h33, r);
        repeat (3) idle_cycle();
        check("R9 no skip while waiting", skip, 1'b0);
        send(8'h21, r); check("R9 decided after gap", r, 1'b1);
        send(8'h33, r); send(8'h55, r); check("R9 unknown second byte", r, 1'b0);
        carry_in = 1'b1; send(8'h20, r); check("R9 back in idle after unknown", r, 1'b1);
        pulse_carry();
        send(8'h33, r); send(8'h41, r); check("R9 timer code after prefix", r, 1'b0);
        send(8'h41, r); check("R9 flag untouched by prefixed 0x41", r, 1'b1);
        send(8'h33, r); send(8'h33, r); check("R9 double prefix", r, 1'b0);
        send(8'h21, r); acc = 4'h1; ram_nib = 4'h1;
        send(8'h21, r); check("R9 idle after double prefix", r, 1'b1);
    endtask

    task automatic t_non_test();
        logic r;
        carry_in = 1'b1; ram_nib = 4'h0; gport = 4'h0; acc = 4'h0;
        send(8'h50, r); check("R10 non-test opcode", r, 1'b0);
        send(8'h00, r); check("R10 opcode 0x00", r, 1'b0);
        send(8'h05, r); check("R10 opcode 0x05", r, 1'b0);
        @(negedge clk);
        instr_byte = 8'h20; instr_valid = 1'b0;
        @(negedge clk);
        check("R10 invalid byte ignored", skip, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_carry();
        t_aeqm();
        t_ram_bits();
        t_gzero();
        t_g_bits();
        t_timer();
        t_prefix_wait();
        t_non_test();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule